// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block tells an SDRAM controller when to issue auto-refresh commands. A free-running interval timer adds one owed refresh to a debt counter each time the average refresh period elapses. The controller may postpone refreshes while it is busy. The debt is held at eight. Once it reaches eight, an urgent flag tells the controller to stop other traffic and drain the owed refreshes. A refresh is requested only when every bank is precharged and the refresh row cycle of the previous refresh has elapsed. The controller accepts a request by raising its grant input in the same cycle.

The block also sequences self refresh. An entry request is taken only when every bank is idle and no refresh cycle or exit window is running. On entry the debt is cleared, the interval timer restarts from zero and then pauses. On exit, two readiness flags open separately: one for any command other than a read after a short window, and one for a read after a much longer window. Precharging the banks before a refresh is left to the controller.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, ref_req, ref_urgent and sr_active are 0, and nonread_ok and read_ok are 1.
- R2: Outside self refresh, one refresh is owed every INTERVAL_CYC cycles. After self-refresh exit the timer runs from zero, so ref_req first rises INTERVAL_CYC+1 cycles after the exit request is sampled, given banks_idle high and no earlier debt.
- R3: ref_req is 1 only when the debt is nonzero, banks_idle is 1, no refresh row cycle is running, self refresh is not active and nonread_ok is 1.
- R4: A grant (ref_gnt high while ref_req is high) lowers the debt by one. ref_gnt while ref_req is low has no effect.
- R5: After a grant, ref_req stays 0 for exactly RFC_CYC cycles.
- R6: The debt never exceeds MAX_DEBT. Intervals that elapse while the debt is full are dropped, so at most MAX_DEBT grants drain a full debt.
- R7: ref_urgent is 1 exactly when the debt equals MAX_DEBT and self refresh is not active.
- R8: sr_enter_req is taken when banks_idle is 1, no refresh row cycle is running, nonread_ok is 1, self refresh is not active and no grant occurs in the same cycle. sr_active is 1 from the next cycle, and the debt and the interval timer are cleared.
- R9: While sr_active is 1, the interval timer is frozen and ref_req and ref_urgent stay 0.
- R10: sr_exit_req while sr_active is 1 ends self refresh on the next cycle. nonread_ok then stays 0 for XS_NONREAD_CYC cycles and read_ok for XS_READ_CYC cycles, counted from the cycle after the exit is sampled.
- R11: sr_enter_req is ignored while banks_idle is 0 or during the non-read exit window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| banks_idle | input | 1 | All banks are precharged |
| ref_gnt | input | 1 | Controller issues the requested refresh this cycle |
| sr_enter_req | input | 1 | Request to enter self refresh |
| sr_exit_req | input | 1 | Request to leave self refresh |
| ref_req | output | 1 | Auto refresh wanted now |
| ref_urgent | output | 1 | Debt is full, so other traffic must yield |
| sr_active | output | 1 | Self refresh in progress |
| nonread_ok | output | 1 | Commands other than read may be issued |
| read_ok | output | 1 | Read commands may be issued |

## Verification
The interval and debt logic is run three ways. With banks busy, debt accumulates without requests. One grant and one stray grant are interleaved, which separates counted grants from ignored ones. A long busy stretch that overfills the debt shows whether saturation drops ticks: the drain must end after exactly eight grants. Self refresh is entered with nonzero debt and left again, which checks that the debt is cleared, the timer restarts, and the two exit windows are timed separately. Entry attempts with banks busy and inside the exit window must be refused.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic {SR_RUN = 1'b0, SR_SLEEP = 1'b1} sr_mode_t;

  // Owed-refresh arithmetic: add the tick, take the grant, clip at the cap.
  function automatic int unsigned debt_step(int unsigned cur, logic up, logic down,
                                            int unsigned cap);
    int unsigned v;
    v = cur + (up ? 1 : 0);
    if (down && v != 0) v = v - 1;
    if (v > cap) v = cap;
    return v;
  endfunction

  // A post-exit window is open once the elapsed count reaches its limit.
  function automatic logic window_done(int unsigned elapsed, int unsigned limit);
    return elapsed >= limit;
  endfunction
endpackage

// File: rtl/rs_interval.sv
module rs_interval #(
  parameter int unsigned INTERVAL_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CNT_W = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (run)     cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rs_debt.sv
module rs_debt #(
  parameter int unsigned MAX_DEBT = 8,
  parameter int unsigned DEBT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              take,
  input  logic              clear,
  output logic [DEBT_W-1:0] debt,
  output logic              full,
  output logic              owed
);
  import rs_pkg::*;

  logic [DEBT_W-1:0] debt_q;
  logic [DEBT_W-1:0] debt_d;

  always_comb debt_d = DEBT_W'(debt_step(int'(debt_q), tick, take, MAX_DEBT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     debt_q <= '0;
    else if (clear) debt_q <= '0;
    else            debt_q <= debt_d;
  end

  assign debt = debt_q;
  assign full = (debt_q == DEBT_W'(MAX_DEBT));
  assign owed = (debt_q != '0);
endmodule

// File: rtl/rs_rfc_gap.sv
module rs_rfc_gap #(
  parameter int unsigned RFC_CYC = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned GAP_W = $clog2(RFC_CYC + 1);

  logic [GAP_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start)          left_q <= GAP_W'(RFC_CYC);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/rs_selfref.sv
module rs_selfref #(
  parameter int unsigned XS_NONREAD_CYC = 15,
  parameter int unsigned XS_READ_CYC    = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_fire,
  input  logic exit_fire,
  output logic active,
  output logic nonread_ok,
  output logic read_ok
);
  import rs_pkg::*;
  localparam int unsigned POST_W = $clog2(XS_READ_CYC + 1);

  sr_mode_t          mode_q;
  logic [POST_W-1:0] post_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SR_RUN;
      post_q <= POST_W'(XS_READ_CYC);
    end else if (enter_fire) begin
      mode_q <= SR_SLEEP;
    end else if (exit_fire) begin
      mode_q <= SR_RUN;
      post_q <= '0;
    end else if (post_q != POST_W'(XS_READ_CYC)) begin
      post_q <= post_q + 1'b1;
    end
  end

  assign active     = (mode_q == SR_SLEEP);
  assign nonread_ok = !active && window_done(int'(post_q), XS_NONREAD_CYC);
  assign read_ok    = !active && window_done(int'(post_q), XS_READ_CYC);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned INTERVAL_CYC   = 1560,
  parameter int unsigned MAX_DEBT       = 8,
  parameter int unsigned RFC_CYC        = 14,
  parameter int unsigned XS_NONREAD_CYC = 15,
  parameter int unsigned XS_READ_CYC    = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic ref_gnt,
  input  logic sr_enter_req,
  input  logic sr_exit_req,
  output logic ref_req,
  output logic ref_urgent,
  output logic sr_active,
  output logic nonread_ok,
  output logic read_ok
);
  localparam int unsigned DEBT_W = $clog2(MAX_DEBT + 1);

  // Named internal events, observed by the bound checker.
  logic              tick_ev;
  logic              grant_fire;
  logic              enter_fire;
  logic              exit_fire;
  logic              rfc_busy;
  logic              debt_full;
  logic              debt_owed;
  logic              quiet_ok;
  logic [DEBT_W-1:0] debt_level;

  assign quiet_ok   = banks_idle && !rfc_busy && nonread_ok;
  assign ref_req    = debt_owed && quiet_ok && !sr_active;
  assign grant_fire = ref_gnt && ref_req;
  assign enter_fire = sr_enter_req && quiet_ok && !sr_active && !grant_fire;
  assign exit_fire  = sr_exit_req && sr_active;
  assign ref_urgent = debt_full && !sr_active;

  rs_interval #(.INTERVAL_CYC(INTERVAL_CYC)) u_interval (
    .clk(clk), .rst_n(rst_n), .run(!sr_active), .restart(enter_fire), .tick(tick_ev)
  );

  rs_debt #(.MAX_DEBT(MAX_DEBT), .DEBT_W(DEBT_W)) u_debt (
    .clk(clk), .rst_n(rst_n), .tick(tick_ev), .take(grant_fire), .clear(enter_fire),
    .debt(debt_level), .full(debt_full), .owed(debt_owed)
  );

  rs_rfc_gap #(.RFC_CYC(RFC_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(grant_fire), .busy(rfc_busy)
  );

  rs_selfref #(.XS_NONREAD_CYC(XS_NONREAD_CYC), .XS_READ_CYC(XS_READ_CYC)) u_sr (
    .clk(clk), .rst_n(rst_n), .enter_fire(enter_fire), .exit_fire(exit_fire),
    .active(sr_active), .nonread_ok(nonread_ok), .read_ok(read_ok)
  );
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int unsigned MAX_DEBT = 8,
  parameter int unsigned DEBT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              banks_idle,
  input logic              ref_req,
  input logic              ref_urgent,
  input logic              sr_active,
  input logic              nonread_ok,
  input logic              read_ok,
  input logic [DEBT_W-1:0] debt_level,
  input logic              grant_fire,
  input logic              enter_fire
);
  AST_REQ_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> banks_idle && !sr_active && nonread_ok); // R3
  AST_REQ_NEEDS_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> debt_level != '0); // R3
  AST_GAP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |=> !ref_req); // R5
  AST_DEBT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(debt_level) <= MAX_DEBT); // R6
  AST_URGENT_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> int'(debt_level) == MAX_DEBT); // R7
  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    enter_fire |=> sr_active && debt_level == '0); // R8
  AST_QUIET_IN_SR: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> !ref_req && !ref_urgent); // R9
  AST_READ_AFTER_NONREAD: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |-> nonread_ok); // R10
  AST_EXIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_active) |-> !nonread_ok && !read_ok); // R10
endmodule

bind refresh_sched rs_checker #(.MAX_DEBT(MAX_DEBT), .DEBT_W(DEBT_W)) u_rs_checker (
  .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .ref_req(ref_req),
  .ref_urgent(ref_urgent), .sr_active(sr_active), .nonread_ok(nonread_ok),
  .read_ok(read_ok), .debt_level(debt_level), .grant_fire(grant_fire),
  .enter_fire(enter_fire)
);

// File: tb/refresh_sched_tb_top.sv
`timescale 1ns/1ps
module refresh_sched_tb_top;
  localparam int INT_C = 1560;
  localparam int CAP   = 8;
  localparam int RFC   = 14;
  localparam int XSN   = 15;
  localparam int XSR   = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic banks_idle = 1'b0, ref_gnt = 1'b0, sr_enter_req = 1'b0, sr_exit_req = 1'b0;
  logic ref_req, ref_urgent, sr_active, nonread_ok, read_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  refresh_sched dut_i (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .ref_gnt(ref_gnt),
    .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .sr_active(sr_active), .nonread_ok(nonread_ok),
    .read_ok(read_ok)
  );

  // Behavioural reference: plain integers updated once per clock.
  int m_phase, m_owed, m_gap, m_since_exit, m_ticks;
  bit m_sleep;

  function automatic bit m_nonread(); return !m_sleep && m_since_exit >= XSN; endfunction
  function automatic bit m_read();    return !m_sleep && m_since_exit >= XSR; endfunction
  function automatic bit m_req();
    return m_owed > 0 && banks_idle && m_gap == 0 && !m_sleep && m_nonread();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_owed = 0; m_gap = 0; m_since_exit = XSR; m_sleep = 0; m_ticks = 0;
    end else begin
      bit took, ticked, goes_in, comes_out;
      took      = ref_gnt && m_req();
      ticked    = !m_sleep && m_phase == INT_C - 1;
      goes_in   = !m_sleep && sr_enter_req && banks_idle && m_gap == 0 && m_nonread() && !took;
      comes_out = m_sleep && sr_exit_req;
      if (ticked) m_ticks++;
      m_gap = took ? RFC : (m_gap > 0 ? m_gap - 1 : 0);
      if (goes_in) begin
        m_sleep = 1; m_owed = 0; m_phase = 0;
      end else if (comes_out) begin
        m_sleep = 0; m_since_exit = 0;
      end else begin
        if (m_since_exit < XSR) m_since_exit++;
        if (!m_sleep) begin
          m_phase = ticked ? 0 : m_phase + 1;
          m_owed = m_owed + int'(ticked) - int'(took);
          if (m_owed > CAP) m_owed = CAP;
        end
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3",  ref_req,    m_req(),                  "ref_req vs model");
      chk("R7",  ref_urgent, m_owed == CAP && !m_sleep, "ref_urgent vs model");
      chk("R8",  sr_active,  m_sleep,                  "sr_active vs model");
      chk("R10", nonread_ok, m_nonread(),              "nonread_ok vs model");
      chk("R10", read_ok,    m_read(),                 "read_ok vs model");
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic steps(int n); for (int i = 0; i < n; i++) step(); endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n, nr_low, rd_low, grants, seen_sr;
    // R1: reset values
    steps(3);
    @(negedge clk);
    chk("R1", ref_req, 1'b0, "ref_req in reset");
    chk("R1", ref_urgent, 1'b0, "ref_urgent in reset");
    chk("R1", sr_active, 1'b0, "sr_active in reset");
    chk("R1", nonread_ok, 1'b1, "nonread_ok in reset");
    chk("R1", read_ok, 1'b1, "read_ok in reset");
    step(); rst_n = 1'b1;

    // Banks busy: debt builds to two, no request (R3)
    steps(2 * INT_C + 10);
    @(negedge clk); chk("R3", ref_req, 1'b0, "no request with banks busy");
    step(); ref_gnt = 1'b1; step(); ref_gnt = 1'b0;   // stray grant, R4
    banks_idle = 1'b1;
    @(negedge clk); chk("R2", ref_req, 1'b1, "two intervals owed");
    step(); ref_gnt = 1'b1; step(); ref_gnt = 1'b0;
    for (int i = 0; i < RFC; i++) begin
      @(negedge clk); chk("R5", ref_req, 1'b0, "refresh row cycle gap");
    end
    @(negedge clk); chk("R4", ref_req, 1'b1, "stray grant was ignored");
    step(); ref_gnt = 1'b1; step(); ref_gnt = 1'b0;
    steps(RFC + 1);
    @(negedge clk); chk("R4", ref_req, 1'b0, "debt drained by two grants");

    // Overfill: ten intervals with banks busy, then drain (R6, R7)
    banks_idle = 1'b0;
    steps(10 * INT_C);
    while (m_phase != 5) step();
    @(negedge clk); chk("R7", ref_urgent, 1'b1, "urgent at full debt");
    step(); banks_idle = 1'b1; ref_gnt = 1'b1;
    grants = 0;
    for (int i = 0; i < CAP * (RFC + 1) + 40; i++) begin
      @(negedge clk); if (ref_req && ref_gnt) grants++;
    end
    step(); ref_gnt = 1'b0;
    chk_int("R6", grants, CAP, "grants draining a full debt");
    chk("R7", ref_urgent, 1'b0, "urgent clear after drain");

    // Entry refused with banks busy (R11)
    banks_idle = 1'b0; sr_enter_req = 1'b1; steps(3); sr_enter_req = 1'b0;
    @(negedge clk); chk("R11", sr_active, 1'b0, "entry refused with banks busy");

    // Build debt then enter self refresh (R8)
    step(); banks_idle = 1'b1;
    steps(2 * INT_C);
    @(negedge clk); chk("R8", ref_req, 1'b1, "debt owed before entry");
    step(); sr_enter_req = 1'b1; step(); sr_enter_req = 1'b0;
    @(negedge clk); chk("R8", sr_active, 1'b1, "self refresh entered");

    // Sleep through three intervals (R9)
    n = 0;
    for (int i = 0; i < 3 * INT_C; i++) begin
      @(negedge clk); if (ref_req || ref_urgent) n++;
    end
    chk_int("R9", n, 0, "request cycles during self refresh");

    // Exit and time both windows; try entry inside the window (R10, R11)
    step(); sr_exit_req = 1'b1;
    nr_low = 0; rd_low = 0; seen_sr = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      if (i == 0) sr_exit_req = 1'b0;
      sr_enter_req = (i == 4);
      #3;
      if (!nonread_ok) nr_low++;
      if (!read_ok) rd_low++;
      if (sr_active) seen_sr++;
    end
    sr_enter_req = 1'b0;
    chk_int("R10", nr_low, XSN, "cycles nonread_ok low");
    chk_int("R10", rd_low, XSR, "cycles read_ok low");
    chk_int("R11", seen_sr, 0, "entry refused in exit window");
    chk("R8", ref_req, 1'b0, "debt cleared by entry");

    // Timer restarted at exit: request rises INT_C+1 cycles after the exit edge,
    // 300 of which the window loop already consumed.
    n = 0;
    while (!ref_req && n < 2 * INT_C) begin
      @(negedge clk); if (!ref_req) n++;
    end
    chk_int("R2", n, INT_C + 1 - 300, "cycles to first request after exit");
    steps(2);
    finish_run();
  end
endmodule